// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves a virtual page number that was not found in the translation cache. It reads a tree of page tables held in memory, one table per level. The walk starts at a root table whose page number is given with the request. At each level the block takes the next slice of the virtual page number and uses it as an index into the current table. Each entry above the last level holds the page number of the next table. The entry at the last level holds the physical page number.

All reads go out over one memory read port, and only one read is in flight at a time. When the entry at the last level is valid, the block returns the physical page number and the full physical address, which is that page number joined to the untouched page offset. When the walk meets an entry whose valid bit is clear, it stops and reports a fault together with the level where the walk stopped.

The number of levels, the slice width, the page number width, the offset width and the entry size are all parameters.

Top module: `page_walker`

## Requirements
- R1: While `rst` is high and after it is released, `req_ready` is 1 and `mem_req`, `walk_done` and `walk_fault` are 0 until a request arrives.
- R2: A request is accepted only when `req_ready` is 1. `req_ready` falls in the cycle after acceptance, and `req_valid` has no effect during a walk: the result is that of the accepted request.
- R3: The first read address is `{req_root, S1} * ENTRY_BYTES`. S1 is the most significant `SLICE_W` bits of `req_vpn`.
- R4: Each later read address is `{B, Sn} * ENTRY_BYTES`. B is bits `[PPN_W-1:0]` of the previous entry and Sn is the next less significant slice of the virtual page number.
- R5: The block issues one read per level, each as a one-cycle `mem_req` pulse, and never has more than one read outstanding. A walk that completes issues exactly `LEVELS` reads.
- R6: When the last-level entry has its valid bit (bit `PPN_W`) set, `ppn_out` equals that entry's bits `[PPN_W-1:0]` and `pa_out` equals `{ppn_out, req_off}`. `walk_done` pulses high for one cycle.
- R7: When an entry read at level L (0 is the root table) has bit `PPN_W` clear, `walk_fault` pulses for one cycle with `fault_level` = L. No further read is issued for that request.
- R8: `walk_done` and `walk_fault` are never high together, and a new request is accepted once a walk has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker is idle and can accept a request |
| req_root | input | PPN_W | Page number of the root table |
| req_vpn | input | LEVELS*SLICE_W | Virtual page number to translate |
| req_off | input | OFF_W | Page offset, passed through unchanged |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | PPN_W+SLICE_W+log2(ENTRY_BYTES) | Byte address of the table entry to read |
| mem_ack | input | 1 | Read data valid |
| mem_data | input | PPN_W+1 | Entry: valid bit on top, page number below |
| walk_done | output | 1 | One-cycle pulse when the translation succeeds |
| walk_fault | output | 1 | One-cycle pulse when an invalid entry is met |
| fault_level | output | max(1,log2(LEVELS)) | Level at which the fault occurred |
| ppn_out | output | PPN_W | Translated physical page number |
| pa_out | output | PPN_W+OFF_W | Translated physical address |

## Verification
The hardest case to reach is a request that arrives while a walk is running with a read still pending. The stimulus raises `req_valid` with a different root and page number during the cycle the first read goes out. It then checks that the whole walk, and the reads it issues, still follow the original request. Faults at each level are forced by clearing the chosen entry in the bench memory. Random walks over a randomly filled table tree, with random memory latency, cover the rest, and each read address is compared with a walk done by a bench function.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } ptw_state_e;
endpackage

// File: rtl/ptw_slice_mux.sv
module ptw_slice_mux #(
  parameter int LEVELS  = 2,
  parameter int SLICE_W = 4,
  parameter int LVL_W   = 1
) (
  input  logic [LEVELS*SLICE_W-1:0] vpn,
  input  logic [LVL_W-1:0]          sel,
  output logic [SLICE_W-1:0]        slice
);
  logic [SLICE_W-1:0] parts [LEVELS];

  // level 0 takes the most significant slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_part
    assign parts[g] = vpn[(LEVELS-g)*SLICE_W-1 -: SLICE_W];
  end

  always_comb begin
    slice = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (sel == LVL_W'(i)) slice = parts[i];
    end
  end
endmodule

// File: rtl/ptw_addr_form.sv
module ptw_addr_form #(
  parameter int PPN_W   = 6,
  parameter int SLICE_W = 4,
  parameter int ESH     = 1,
  parameter int MADDR_W = PPN_W + SLICE_W + ESH
) (
  input  logic [PPN_W-1:0]   base,
  input  logic [SLICE_W-1:0] slice,
  output logic [MADDR_W-1:0] addr
);
  if (ESH == 0) begin : g_noscale
    assign addr = {base, slice};
  end else begin : g_scale
    assign addr = {base, slice, {ESH{1'b0}}};
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int LEVELS  = 2,
  parameter int SLICE_W = 4,
  parameter int PPN_W   = 6,
  parameter int OFF_W   = 6,
  parameter int LVL_W   = 1,
  parameter int MADDR_W = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [PPN_W-1:0]          req_root,
  input  logic [LEVELS*SLICE_W-1:0] req_vpn,
  input  logic [OFF_W-1:0]          req_off,
  output logic                      mem_req,
  output logic [MADDR_W-1:0]        mem_addr,
  input  logic                      mem_ack,
  input  logic [PPN_W:0]            mem_data,
  input  logic [MADDR_W-1:0]        nxt_addr,
  output logic [LEVELS*SLICE_W-1:0] src_vpn,
  output logic [LVL_W-1:0]          src_lvl,
  output logic [PPN_W-1:0]          src_base,
  output logic                      walk_done,
  output logic                      walk_fault,
  output logic [LVL_W-1:0]          fault_level,
  output logic [PPN_W-1:0]          ppn_out,
  output logic [PPN_W+OFF_W-1:0]    pa_out
);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS-1);

  ptw_state_e                state_q;
  logic [LVL_W-1:0]          level_q;
  logic [LEVELS*SLICE_W-1:0] vpn_q;
  logic [OFF_W-1:0]          off_q;
  logic [MADDR_W-1:0]        addr_q;
  logic                      done_q, fault_q;
  logic [LVL_W-1:0]          flvl_q;
  logic [PPN_W-1:0]          ppn_q;
  logic [PPN_W+OFF_W-1:0]    pa_q;
  logic                      ent_valid;
  logic [PPN_W-1:0]          ent_base;

  assign ent_valid = mem_data[PPN_W];
  assign ent_base  = mem_data[PPN_W-1:0];

  always_comb begin
    if (state_q == ST_IDLE) begin
      src_vpn  = req_vpn;
      src_lvl  = '0;
      src_base = req_root;
    end else begin
      src_vpn  = vpn_q;
      src_lvl  = (level_q == LAST) ? level_q : level_q + LVL_W'(1);
      src_base = ent_base;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      level_q <= '0;
      vpn_q   <= '0;
      off_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
      ppn_q   <= '0;
      pa_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q   <= req_vpn;
            off_q   <= req_off;
            level_q <= '0;
            addr_q  <= nxt_addr;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_ack) begin
            if (!ent_valid) begin
              fault_q <= 1'b1;
              flvl_q  <= level_q;
              state_q <= ST_FIN;
            end else if (level_q == LAST) begin
              done_q  <= 1'b1;
              ppn_q   <= ent_base;
              pa_q    <= {ent_base, off_q};
              state_q <= ST_FIN;
            end else begin
              level_q <= level_q + LVL_W'(1);
              addr_q  <= nxt_addr;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign mem_req     = (state_q == ST_ISSUE);
  assign mem_addr    = addr_q;
  assign walk_done   = done_q;
  assign walk_fault  = fault_q;
  assign fault_level = flvl_q;
  assign ppn_out     = ppn_q;
  assign pa_out      = pa_q;

  // R5: a read request lasts one cycle
  a_r5_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R5: the address holds while a read is outstanding
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> $stable(mem_addr));
  // R2: acceptance starts a read and drops ready
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_req && !req_ready));
  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> !walk_done);
  // R7: no read follows a fault, and the level is in range
  a_r7_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    walk_fault |-> (!mem_req && fault_level <= LAST));
  // R8: done and fault are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(walk_done && walk_fault));
endmodule

// File: rtl/page_walker.sv
module page_walker #(
  parameter int LEVELS      = 2,
  parameter int SLICE_W     = 4,
  parameter int PPN_W       = 6,
  parameter int OFF_W       = 6,
  parameter int ENTRY_BYTES = 2,
  localparam int ESH        = (ENTRY_BYTES > 1) ? $clog2(ENTRY_BYTES) : 0,
  localparam int LVL_W      = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int VPN_W      = LEVELS * SLICE_W,
  localparam int MADDR_W    = PPN_W + SLICE_W + ESH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [PPN_W-1:0]       req_root,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  output logic                   mem_req,
  output logic [MADDR_W-1:0]     mem_addr,
  input  logic                   mem_ack,
  input  logic [PPN_W:0]         mem_data,
  output logic                   walk_done,
  output logic                   walk_fault,
  output logic [LVL_W-1:0]       fault_level,
  output logic [PPN_W-1:0]       ppn_out,
  output logic [PPN_W+OFF_W-1:0] pa_out
);
  logic [VPN_W-1:0]   src_vpn;
  logic [LVL_W-1:0]   src_lvl;
  logic [PPN_W-1:0]   src_base;
  logic [SLICE_W-1:0] cur_slice;
  logic [MADDR_W-1:0] nxt_addr;

  ptw_slice_mux #(.LEVELS(LEVELS), .SLICE_W(SLICE_W), .LVL_W(LVL_W)) u_slice (
    .vpn(src_vpn), .sel(src_lvl), .slice(cur_slice));

  ptw_addr_form #(.PPN_W(PPN_W), .SLICE_W(SLICE_W), .ESH(ESH), .MADDR_W(MADDR_W)) u_addr (
    .base(src_base), .slice(cur_slice), .addr(nxt_addr));

  ptw_ctrl #(.LEVELS(LEVELS), .SLICE_W(SLICE_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
             .LVL_W(LVL_W), .MADDR_W(MADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_root(req_root), .req_vpn(req_vpn), .req_off(req_off),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .nxt_addr(nxt_addr), .src_vpn(src_vpn), .src_lvl(src_lvl), .src_base(src_base),
    .walk_done(walk_done), .walk_fault(walk_fault), .fault_level(fault_level),
    .ppn_out(ppn_out), .pa_out(pa_out));
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
  localparam int LV = 2, SW = 4, PW = 6, OW = 6, EB = 2, ESH = 1;
  localparam int AW = PW + SW + ESH;
  localparam int WORDS = 1 << (PW + SW);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, req_valid, req_ready, mem_req, mem_ack, walk_done, walk_fault;
  logic [PW-1:0] req_root, ppn_out;
  logic [LV*SW-1:0] req_vpn;
  logic [OW-1:0] req_off;
  logic [AW-1:0] mem_addr;
  logic [PW:0] mem_data;
  logic [0:0] fault_level;
  logic [PW+OW-1:0] pa_out;

  page_walker #(.LEVELS(LV), .SLICE_W(SW), .PPN_W(PW), .OFF_W(OW), .ENTRY_BYTES(EB)) i_page_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_root(req_root), .req_vpn(req_vpn), .req_off(req_off),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .walk_done(walk_done), .walk_fault(walk_fault), .fault_level(fault_level),
    .ppn_out(ppn_out), .pa_out(pa_out));

  logic [PW:0] pt_mem [0:WORDS-1];
  int n_checks = 0, n_err = 0;
  int reads_seen = 0, lat = 1;
  logic [AW-1:0] exp_addr [0:LV-1];
  int exp_nreads, exp_flvl;
  bit exp_fault;
  logic [PW-1:0] exp_ppn;

  task automatic chk(bit ok, string rq, string what, longint act, longint expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  task automatic put(int base, int slc, bit v, int val);
    pt_mem[base*(1<<SW) + slc] = {v, PW'(val)};
  endtask

  task automatic compute_exp(logic [PW-1:0] root, logic [LV*SW-1:0] vpn);
    logic [PW-1:0] b;
    logic [PW:0] e;
    int s;
    b = root; exp_fault = 0; exp_nreads = 0; exp_flvl = 0; exp_ppn = '0;
    for (int l = 0; l < LV; l++) begin
      s = int'((vpn >> ((LV-1-l)*SW)) & ((1<<SW)-1));
      exp_addr[l] = AW'((int'(b) * (1<<SW) + s) * EB);
      e = pt_mem[int'(b) * (1<<SW) + s];
      exp_nreads++;
      if (!e[PW]) begin exp_fault = 1; exp_flvl = l; break; end
      b = e[PW-1:0];
      if (l == LV-1) exp_ppn = b;
    end
  endtask

  // memory responder
  initial begin
    mem_ack = 1'b0; mem_data = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (!rst && mem_req) begin
        logic [AW-1:0] a;
        a = mem_addr;
        chk(reads_seen < LV, "R5", "reads per walk", reads_seen + 1, LV);
        if (reads_seen < LV)
          chk(a == exp_addr[reads_seen], reads_seen == 0 ? "R3" : "R4",
              "read address", a, exp_addr[reads_seen]);
        reads_seen++;
        repeat (lat) @(negedge clk);
        mem_ack = 1'b1;
        mem_data = pt_mem[a >> ESH];
      end
    end
  end

  task automatic run_walk(logic [PW-1:0] root, logic [LV*SW-1:0] vpn, logic [OW-1:0] off, bit intrude);
    int cnt;
    compute_exp(root, vpn);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    reads_seen = 0;
    req_valid = 1'b1; req_root = root; req_vpn = vpn; req_off = off;
    @(negedge clk);
    chk(!req_ready, "R2", "ready after accept", req_ready, 0);
    chk(mem_req, "R3", "first read issued", mem_req, 1);
    if (intrude) begin
      req_root = ~root; req_vpn = ~vpn; req_off = ~off;
      @(negedge clk);
    end
    req_valid = 1'b0;
    cnt = 0;
    while (!walk_done && !walk_fault && cnt < 100) begin @(negedge clk); cnt++; end
    chk(cnt < 100, "R6", "walk completes", cnt, 0);
    chk(!(walk_done && walk_fault), "R8", "done/fault exclusive", {walk_done, walk_fault}, 0);
    chk(walk_fault == exp_fault, "R7", "fault flag", walk_fault, exp_fault);
    if (exp_fault) begin
      chk(fault_level == exp_flvl[0:0], "R7", "fault level", fault_level, exp_flvl);
    end else begin
      chk(ppn_out == exp_ppn, intrude ? "R2" : "R6", "ppn", ppn_out, exp_ppn);
      chk(pa_out == {exp_ppn, off}, "R6", "physical address", pa_out, {exp_ppn, off});
    end
    @(negedge clk);
    chk(!walk_done && !walk_fault, "R6", "one-cycle pulse", {walk_done, walk_fault}, 0);
    repeat (3) @(negedge clk);
    chk(reads_seen == exp_nreads, exp_fault ? "R7" : "R5", "read count", reads_seen, exp_nreads);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; req_valid = 1'b0; req_root = '0; req_vpn = '0; req_off = '0;
    for (int i = 0; i < WORDS; i++) pt_mem[i] = {($urandom % 8) != 0, PW'($urandom)};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !mem_req && !walk_done && !walk_fault, "R1", "reset outputs",
        {req_ready, mem_req, walk_done, walk_fault}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req && !walk_done && !walk_fault, "R1", "idle after reset",
        {req_ready, mem_req, walk_done, walk_fault}, 4'b1000);

    // directed: success through two valid entries
    put(5, 4'hA, 1, 6'h2C); put(6'h2C, 4'h3, 1, 6'h11);
    lat = 1; run_walk(6'd5, 8'hA3, 6'h15, 0);
    chk(ppn_out == 6'h11, "R6", "directed ppn", ppn_out, 6'h11);
    // fault at root level
    put(7, 2, 0, 0);
    lat = 2; run_walk(6'd7, 8'h29, 6'h01, 0);
    chk(fault_level == 1'b0, "R7", "root fault level", fault_level, 0);
    // fault at last level
    put(9, 1, 1, 6'h30); put(6'h30, 4'hE, 0, 0);
    lat = 3; run_walk(6'd9, 8'h1E, 6'h3F, 0);
    chk(fault_level == 1'b1, "R7", "leaf fault level", fault_level, 1);
    // extreme indices
    put(63, 15, 1, 63); put(63, 15, 1, 63);
    lat = 1; run_walk(6'h3F, 8'hFF, 6'h3F, 0);
    // request during a walk is ignored
    put(3, 4, 1, 6'h21); put(6'h21, 5, 1, 6'h0B);
    lat = 2; run_walk(6'd3, 8'h45, 6'h2A, 1);
    // back-to-back and random walks
    for (int n = 0; n < 80; n++) begin
      lat = 1 + int'($urandom % 4);
      run_walk(PW'($urandom), (LV*SW)'($urandom), OW'($urandom), ($urandom % 5) == 0);
    end
    report();
  end
endmodule